// File: doc/BRIEF.md
# Page History Bit Update Controller

This block sits beside a memory management unit's translation lookaside buffer and decides, for each translated access, whether a page-table search must be launched to record that the page was referenced (R) or modified (C). It looks at the access kind, where the translation came from, whether the segment is a direct-store segment, the two translation-enable flags, and the R and C bits of the matching buffer entry. From these it builds a search request with per-bit "set" flags.

The request goes to an external table walker over a valid/ready handshake. The walker then signals completion with a one-cycle done pulse. Only one update can be in flight. While it is, the block reports busy and drops any new access. When a search that set C in the page table finishes, a one-cycle strobe tells the buffer to set C in its own entry. A buffer hit whose entry shows R clear is an impossible state. Such an access raises a one-cycle error pulse and is otherwise dropped.

Top module: `hist_upd_ctrl`

## Requirements
- R1: An access with `xlat_src` = 2 (block-address translation) never produces a request.
- R2: An access with `seg_direct` = 1 (direct-store segment) never produces a request.
- R3: An access with both `itrans_en` and `dtrans_en` at 0 never produces a request. Also, `acc_kind` = 3 and `xlat_src` = 3 are reserved and never produce a request.
- R4: On a buffer hit (`xlat_src` = 0) with R=1, C=0, the following apply:
  - A load (`acc_kind` = 0) produces no request.
  - A store (`acc_kind` = 1) produces a request with `walk_set_ref`=0 and `walk_set_chg`=1.
- R5: On a buffer hit with R=1, C=1, no request is made for any access kind.
- R6: On a buffer miss (`xlat_src` = 1), a request is always made with `walk_set_ref`=1. `walk_set_chg` is 1 for a store and 0 otherwise.
- R7: A touch access (`acc_kind` = 2) never sets `walk_set_chg`. It requests on a miss and does not request on a hit.
- R8: An eligible buffer hit with R=0 gives `illegal_hit` high for exactly the one cycle after acceptance, and produces no request.
- R9: After acceptance, the request is handled as follows:
  - `walk_req_valid` and `busy` rise one cycle after acceptance.
  - The flags hold steady until `walk_req_ready`.
  - `busy` stays high until the cycle after `walk_done`.
  - Accesses offered while busy are ignored.
- R10: `chg_strobe` is high for exactly the one cycle after a completed search whose `walk_set_chg` was 1, and is never high otherwise.
- R11: While `rst_n` is low, the outputs are as follows:
  - `busy`, `walk_req_valid`, `chg_strobe` and `illegal_hit` are 0.
  - There is no pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access offered; accepted when `busy` is 0 |
| acc_kind | input | 2 | 0 load, 1 store, 2 touch, 3 reserved |
| xlat_src | input | 2 | 0 buffer hit, 1 buffer miss, 2 block translation, 3 reserved |
| seg_direct | input | 1 | Direct-store segment |
| itrans_en | input | 1 | Instruction translation enabled |
| dtrans_en | input | 1 | Data translation enabled |
| tlb_ref | input | 1 | R bit of the hit entry |
| tlb_chg | input | 1 | C bit of the hit entry |
| walk_req_valid | output | 1 | Search request pending |
| walk_req_ready | input | 1 | Walker takes the request |
| walk_set_ref | output | 1 | Search must set R |
| walk_set_chg | output | 1 | Search must set C |
| walk_done | input | 1 | Walker finished the search |
| busy | output | 1 | Update in flight |
| chg_strobe | output | 1 | Set C in the buffer entry |
| illegal_hit | output | 1 | Hit with R=0 seen |

## Verification
The completion strobe of one update and the acceptance of the next access can fall in the same cycle, because `busy` drops on the same edge that raises `chg_strobe`. The bench finishes a store-miss search and then offers a load miss in the very cycle the strobe is high. It checks that the strobe is still a single pulse. It also checks that the new request carries only the R flag.

// File: rtl/hist_pkg.sv
package hist_pkg;
  typedef enum logic [1:0] {
    AK_LOAD  = 2'd0,
    AK_STORE = 2'd1,
    AK_TOUCH = 2'd2,
    AK_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    XS_HIT   = 2'd0,
    XS_MISS  = 2'd1,
    XS_BLOCK = 2'd2,
    XS_RSVD  = 2'd3
  } xlat_src_e;

  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_REQ  = 2'd1,
    TS_WAIT = 2'd2
  } trk_state_e;

  typedef struct packed {
    logic need;
    logic set_ref;
    logic set_chg;
    logic illegal;
  } upd_dec_t;
endpackage

// File: rtl/hist_decide.sv
module hist_decide
  import hist_pkg::*;
(
  input  acc_kind_e kind,
  input  xlat_src_e src,
  input  logic      seg_direct,
  input  logic      itrans_en,
  input  logic      dtrans_en,
  input  logic      tlb_ref,
  input  logic      tlb_chg,
  output upd_dec_t  dec
);
  logic eligible;
  logic is_store;
  logic kind_ok;

  always_comb begin
    kind_ok  = (kind != AK_RSVD);
    is_store = (kind == AK_STORE);
    eligible = (itrans_en | dtrans_en) & ~seg_direct & kind_ok &
               ((src == XS_HIT) | (src == XS_MISS));
    dec = '0;
    if (eligible) begin
      if (src == XS_MISS) begin
        dec.need    = 1'b1;
        dec.set_ref = 1'b1;
        dec.set_chg = is_store;
      end else if (!tlb_ref) begin
        dec.illegal = 1'b1;
      end else if (is_store && !tlb_chg) begin
        dec.need    = 1'b1;
        dec.set_chg = 1'b1;
      end
    end
  end

  // R7: touch accesses never ask for C
  always_comb begin
    if (kind == AK_TOUCH) assert (!dec.set_chg);
  end
endmodule

// File: rtl/hist_track.sv
module hist_track
  import hist_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     acc_valid,
  input  upd_dec_t dec,
  input  logic     walk_req_ready,
  input  logic     walk_done,
  output logic     busy,
  output logic     walk_req_valid,
  output logic     walk_set_ref,
  output logic     walk_set_chg,
  output logic     chg_strobe,
  output logic     illegal_hit
);
  trk_state_e state_q, state_d;
  logic       ref_q, chg_q;
  logic       strobe_q, strobe_d;
  logic       ill_q, ill_d;
  logic       accept;
  logic       flag_en;

  always_comb begin
    accept   = acc_valid && (state_q == TS_IDLE);
    flag_en  = accept && dec.need;
    ill_d    = accept && dec.illegal;
    strobe_d = (state_q == TS_WAIT) && walk_done && chg_q;
    state_d  = state_q;
    case (state_q)
      TS_IDLE: if (flag_en)        state_d = TS_REQ;
      TS_REQ:  if (walk_req_ready) state_d = TS_WAIT;
      TS_WAIT: if (walk_done)      state_d = TS_IDLE;
      default:                     state_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= TS_IDLE;
      strobe_q <= 1'b0;
      ill_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      strobe_q <= strobe_d;
      ill_q    <= ill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      chg_q <= 1'b0;
    end else if (flag_en) begin
      ref_q <= dec.set_ref;
      chg_q <= dec.set_chg;
    end
  end

  assign busy           = (state_q != TS_IDLE);
  assign walk_req_valid = (state_q == TS_REQ);
  assign walk_set_ref   = ref_q;
  assign walk_set_chg   = chg_q;
  assign chg_strobe     = strobe_q;
  assign illegal_hit    = ill_q;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid && !walk_req_ready |=>
      walk_req_valid && $stable(walk_set_ref) && $stable(walk_set_chg));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !walk_req_valid);
  p_strobe_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    chg_strobe |=> !chg_strobe);
  p_strobe_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_strobe) |-> $past(walk_done) && !busy);
  p_illegal_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_hit |-> !walk_req_valid ##1 !illegal_hit);
endmodule

// File: rtl/hist_upd_ctrl.sv
module hist_upd_ctrl
  import hist_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_valid,
  input  logic [1:0] acc_kind,
  input  logic [1:0] xlat_src,
  input  logic       seg_direct,
  input  logic       itrans_en,
  input  logic       dtrans_en,
  input  logic       tlb_ref,
  input  logic       tlb_chg,
  output logic       walk_req_valid,
  input  logic       walk_req_ready,
  output logic       walk_set_ref,
  output logic       walk_set_chg,
  input  logic       walk_done,
  output logic       busy,
  output logic       chg_strobe,
  output logic       illegal_hit
);
  upd_dec_t dec;

  hist_decide u_decide (
    .kind       (acc_kind_e'(acc_kind)),
    .src        (xlat_src_e'(xlat_src)),
    .seg_direct (seg_direct),
    .itrans_en  (itrans_en),
    .dtrans_en  (dtrans_en),
    .tlb_ref    (tlb_ref),
    .tlb_chg    (tlb_chg),
    .dec        (dec)
  );

  hist_track u_track (
    .clk            (clk),
    .rst_n          (rst_n),
    .acc_valid      (acc_valid),
    .dec            (dec),
    .walk_req_ready (walk_req_ready),
    .walk_done      (walk_done),
    .busy           (busy),
    .walk_req_valid (walk_req_valid),
    .walk_set_ref   (walk_set_ref),
    .walk_set_chg   (walk_set_chg),
    .chg_strobe     (chg_strobe),
    .illegal_hit    (illegal_hit)
  );

  p_no_req_while_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !busy && !itrans_en && !dtrans_en |=> !walk_req_valid);
  p_block_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !busy && xlat_src == 2'd2 |=> !walk_req_valid && !illegal_hit);
endmodule

// File: tb/sim_hist_upd_ctrl.sv
module sim_hist_upd_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       acc_valid;
  logic [1:0] acc_kind;
  logic [1:0] xlat_src;
  logic       seg_direct, itrans_en, dtrans_en, tlb_ref, tlb_chg;
  logic       walk_req_valid, walk_req_ready, walk_set_ref, walk_set_chg;
  logic       walk_done, busy, chg_strobe, illegal_hit;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  hist_upd_ctrl u0 (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input int k, input int s, input int sg, input int ie,
                       input int de, input int r, input int c);
    acc_kind   = 2'(k);
    xlat_src   = 2'(s);
    seg_direct = 1'(sg);
    itrans_en  = 1'(ie);
    dtrans_en  = 1'(de);
    tlb_ref    = 1'(r);
    tlb_chg    = 1'(c);
  endtask

  task automatic finish_walk(input string req, input logic exp_chg);
    walk_req_ready = 1'b1;
    @(negedge clk);
    walk_req_ready = 1'b0;
    chk("R9", "valid after ready", walk_req_valid, 0);
    chk("R9", "busy waiting", busy, 1);
    walk_done = 1'b1;
    @(negedge clk);
    walk_done = 1'b0;
    chk("R9", "busy after done", busy, 0);
    chk(req, "chg_strobe", chg_strobe, exp_chg);
  endtask

  task automatic run_one(input int k, input int s, input int sg, input int ie,
                         input int de, input int r, input int c);
    logic elig, e_ill, e_need, e_ref, e_chg;
    string tag;
    elig   = ((ie | de) != 0) && sg == 0 && s < 2 && k != 3;
    e_ill  = elig && s == 0 && r == 0;
    e_need = elig && (s == 1 || (s == 0 && r == 1 && k == 1 && c == 0));
    e_ref  = (s == 1);
    e_chg  = (k == 1) && (s == 1 || c == 0);
    if (s == 2)            tag = "R1";
    else if (sg == 1)      tag = "R2";
    else if ((ie|de) == 0) tag = "R3";
    else if (k == 3 || s == 3) tag = "R3";
    else if (k == 2)       tag = "R7";
    else if (s == 1)       tag = "R6";
    else if (r == 0)       tag = "R8";
    else if (c == 1)       tag = "R5";
    else                   tag = "R4";
    drive(k, s, sg, ie, de, r, c);
    acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    chk(tag, "walk_req_valid", walk_req_valid, e_need);
    chk("R8", "illegal_hit", illegal_hit, e_ill);
    chk("R9", "busy", busy, e_need);
    if (e_need) begin
      chk(tag, "walk_set_ref", walk_set_ref, e_ref);
      chk(tag, "walk_set_chg", walk_set_chg, e_chg);
      drive(1, 1, 0, 1, 1, 1, 0);
      acc_valid = 1'b1;
      @(negedge clk);
      acc_valid = 1'b0;
      chk("R9", "valid held", walk_req_valid, 1);
      chk("R9", "ref held", walk_set_ref, e_ref);
      chk("R9", "chg held", walk_set_chg, e_chg);
      finish_walk("R10", e_chg);
      @(negedge clk);
      chk("R10", "strobe single", chg_strobe, 0);
      chk("R9", "busy intruder ignored", walk_req_valid, 0);
    end else begin
      @(negedge clk);
      chk("R8", "illegal single", illegal_hit, 0);
      chk("R9", "still idle", busy, 0);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    acc_valid = 1'b0;
    walk_req_ready = 1'b0;
    walk_done = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R11", "busy", busy, 0);
    chk("R11", "walk_req_valid", walk_req_valid, 0);
    chk("R11", "chg_strobe", chg_strobe, 0);
    chk("R11", "illegal_hit", illegal_hit, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 4; s++)
        for (int sg = 0; sg < 2; sg++)
          for (int ie = 0; ie < 2; ie++)
            for (int de = 0; de < 2; de++)
              for (int r = 0; r < 2; r++)
                for (int c = 0; c < 2; c++)
                  run_one(k, s, sg, ie, de, r, c);

    // R10 and R9 together: new access accepted in the strobe cycle
    drive(1, 1, 0, 0, 1, 0, 0);
    acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    finish_walk("R10", 1'b1);
    drive(0, 1, 0, 1, 0, 0, 0);
    acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    chk("R10", "overlap strobe single", chg_strobe, 0);
    chk("R9", "overlap request", walk_req_valid, 1);
    chk("R6", "overlap ref", walk_set_ref, 1);
    chk("R6", "overlap chg", walk_set_chg, 0);
    finish_walk("R10", 1'b0);

    // R11: reset in the middle of a pending request
    drive(1, 1, 0, 1, 1, 0, 0);
    acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11", "reset clears request", walk_req_valid, 0);
    chk("R11", "reset clears busy", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule